// File: doc/BRIEF.md
# Interrupt priority level evaluator

This block turns a set of pending interrupt requests into one priority level and decides whether the processor has to take an interrupt trap. Two sources feed it: a software request word, whose bits in a low range map to levels counted from one, and an external interrupt vector, whose bits in a higher range map to a level equal to their bit index. The highest pending external line always sets the level and overrides any software level. When that level is nonzero and strictly above the current 5-bit priority level, the block raises a trap request for one cycle. In the same cycle it loads a summary word (every pending bit in both ranges) and the winning level into its output registers.

Evaluation is gated by an internal armed flag. Every evaluation clears the flag. It is set again only by a return-from-exception strobe that arrives in privileged mode and is not speculative. The same strobe outside privileged mode raises an illegal-instruction fault pulse and leaves the flag as it was. The block does not support asynchronous trap requests. If that request word is nonzero when an evaluation runs, the block raises an error pulse and takes no trap.

Top module: `ipl_evaluator`

## Requirements
- R1: After synchronous active-low reset, trap_req, err_ast and rfe_fault are 0, sum_word and int_id are 0, and eval_armed is 1.
- R2: A pending software bit i in range 4..18 gives level i-3. The highest such bit sets the software level (bit 4 gives level 1, bit 18 gives level 15).
- R3: A pending external bit i in range 20..30 gives level i. The highest such bit sets the level, and any pending external bit replaces the software level.
- R4: On a trap, sum_word takes the OR of pending software bits 4..18 and external bits 20..30. Bits 0..3, 19 and 31 of either input do not appear in sum_word and give no level.
- R5: A trap is taken only when the level is nonzero and strictly greater than cur_ipl (equal gives no trap). sum_word and int_id change only when a trap is taken and otherwise hold their value.
- R6: When an evaluation runs with ast_req nonzero, err_ast pulses, no trap is taken, and sum_word and int_id are unchanged.
- R7: An evaluation runs in every cycle in which eval_armed is 1, and it clears eval_armed. With eval_armed at 0, no trap and no error are produced.
- R8: rfe_strobe with pal_mode=1 and rfe_spec=0 sets eval_armed on the next cycle. With rfe_spec=1 the strobe leaves eval_armed unchanged.
- R9: rfe_strobe with pal_mode=0 pulses rfe_fault on the next cycle and leaves eval_armed unchanged.
- R10: trap_req, err_ast and rfe_fault are registered. Each is 1 only in the single cycle after its cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_req | input | 32 | Software interrupt request word |
| ext_irq | input | 32 | External interrupt lines |
| cur_ipl | input | 5 | Current priority level |
| ast_req | input | 4 | Asynchronous trap request word (unsupported) |
| pal_mode | input | 1 | Processor is in privileged mode |
| rfe_strobe | input | 1 | Return-from-exception issued |
| rfe_spec | input | 1 | The return is speculative |
| trap_req | output | 1 | One-cycle interrupt trap request |
| sum_word | output | 32 | Latched summary of pending bits |
| int_id | output | 5 | Latched winning level |
| err_ast | output | 1 | One-cycle error: asynchronous trap request seen |
| rfe_fault | output | 1 | One-cycle illegal-instruction fault |
| eval_armed | output | 1 | Evaluation armed flag |

## Verification
The hardest situation to reach from the ports is an evaluation against chosen inputs. The armed flag is cleared by every evaluation, including one run on idle inputs. The stimulus therefore spends one cycle issuing a privileged, non-speculative return with all request inputs at zero, and applies the vector in the next cycle, when exactly one meaningful evaluation runs. Once an evaluation has cleared the flag, requests applied without a return, speculative returns and returns outside privileged mode show that nothing is evaluated, which is observed on trap_req, sum_word and eval_armed.

// File: rtl/ipl_pkg.sv
// Shared types for the interrupt priority level evaluator.
// Assumes: nothing beyond standard SystemVerilog.
package ipl_pkg;
    // How a bit index inside a scanned range maps to a priority level.
    typedef enum logic {
        MAP_REBASED = 1'b0,   // level = index - range_low + 1
        MAP_DIRECT  = 1'b1    // level = index
    } map_e;
endpackage

// File: rtl/ipl_range_scan.sv
// Range scanner: masks a request word to [LO,HI] and finds the level of the
// highest pending bit in that range, using the selected mapping.
// Assumes: LO <= HI < SUM_W, and every produced level fits in LVL_W bits.
module ipl_range_scan #(
    parameter int            SUM_W = 32,
    parameter int            LO    = 4,
    parameter int            HI    = 18,
    parameter int            LVL_W = 5,
    parameter ipl_pkg::map_e MAP   = ipl_pkg::MAP_REBASED
) (
    input  logic [SUM_W-1:0] src,
    output logic [SUM_W-1:0] in_range,
    output logic             hit,
    output logic [LVL_W-1:0] level
);
    // Keep only bits inside the scanned range.
    for (genvar g = 0; g < SUM_W; g++) begin : g_mask
        if (g >= LO && g <= HI) begin : g_in
            assign in_range[g] = src[g];
        end else begin : g_out
            assign in_range[g] = 1'b0;
        end
    end

    assign hit = |in_range;

    // Ascending scan: the last (highest) pending bit decides the level.
    always_comb begin
        level = '0;
        for (int i = LO; i <= HI; i++) begin
            if (src[i]) begin
                if (MAP == ipl_pkg::MAP_DIRECT) level = LVL_W'(i);
                else                            level = LVL_W'(i - LO + 1);
            end
        end
    end

    // R2/R3: a pending bit in range never yields level zero.
    always_comb begin
        a_r2_hit_nonzero_level: assert (!hit || level != '0);
    end
endmodule

// File: rtl/ipl_arm_ctrl.sv
// Arm control: holds the evaluation armed flag and flags illegal returns.
// Evaluation clears the flag; a privileged, non-speculative return sets it
// (set wins over clear in the same cycle); a return outside privileged mode
// raises a one-cycle fault and leaves the flag alone.
// Assumes: synchronous active-low reset; flag armed out of reset.
module ipl_arm_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic eval_now,
    input  logic rfe_strobe,
    input  logic pal_mode,
    input  logic rfe_spec,
    output logic armed,
    output logic fault
);
    logic rearm;
    logic illegal;

    assign rearm   = rfe_strobe && pal_mode && !rfe_spec;
    assign illegal = rfe_strobe && !pal_mode;

    // Armed flag update: rearm has priority over the clear from evaluation.
    always_ff @(posedge clk) begin
        if (!rst_n)        armed <= 1'b1;
        else if (rearm)    armed <= 1'b1;
        else if (eval_now) armed <= 1'b0;
    end

    // One-cycle illegal-return fault pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) fault <= 1'b0;
        else        fault <= illegal;
    end

    a_r8_rearm_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(rfe_strobe && pal_mode && !rfe_spec));
    a_r9_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $past(rfe_strobe && !pal_mode));
    a_r9_fault_keeps_arm: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (armed == $past(armed) || $past(eval_now)));
endmodule

// File: rtl/ipl_evaluator.sv
// Interrupt priority level evaluator (top).
// Combines a software request word and external interrupt lines into one
// level, compares it with the current level and raises a one-cycle trap
// request while latching the summary word and winning level.
// Assumes: synchronous active-low reset; external levels exceed software ones.
module ipl_evaluator #(
    parameter int SUM_W  = 32,
    parameter int SW_LO  = 4,
    parameter int SW_HI  = 18,
    parameter int EXT_LO = 20,
    parameter int EXT_HI = 30,
    parameter int LVL_W  = 5,
    parameter int AST_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SUM_W-1:0] sw_req,
    input  logic [SUM_W-1:0] ext_irq,
    input  logic [LVL_W-1:0] cur_ipl,
    input  logic [AST_W-1:0] ast_req,
    input  logic             pal_mode,
    input  logic             rfe_strobe,
    input  logic             rfe_spec,
    output logic             trap_req,
    output logic [SUM_W-1:0] sum_word,
    output logic [LVL_W-1:0] int_id,
    output logic             err_ast,
    output logic             rfe_fault,
    output logic             eval_armed
);
    logic [SUM_W-1:0] sw_bits, ext_bits;
    logic             sw_hit, ext_hit;
    logic [LVL_W-1:0] sw_lvl, ext_lvl, win_lvl;
    logic             ast_bad, take;

    ipl_range_scan #(.SUM_W(SUM_W), .LO(SW_LO), .HI(SW_HI), .LVL_W(LVL_W),
                     .MAP(ipl_pkg::MAP_REBASED)) u_sw_scan (
        .src(sw_req), .in_range(sw_bits), .hit(sw_hit), .level(sw_lvl));

    ipl_range_scan #(.SUM_W(SUM_W), .LO(EXT_LO), .HI(EXT_HI), .LVL_W(LVL_W),
                     .MAP(ipl_pkg::MAP_DIRECT)) u_ext_scan (
        .src(ext_irq), .in_range(ext_bits), .hit(ext_hit), .level(ext_lvl));

    ipl_arm_ctrl u_arm (
        .clk(clk), .rst_n(rst_n), .eval_now(eval_armed),
        .rfe_strobe(rfe_strobe), .pal_mode(pal_mode), .rfe_spec(rfe_spec),
        .armed(eval_armed), .fault(rfe_fault));

    // External sources are applied after software ones and override them.
    assign win_lvl = ext_hit ? ext_lvl : sw_lvl;
    assign ast_bad = |ast_req;
    assign take    = eval_armed && !ast_bad && (win_lvl != '0) && (win_lvl > cur_ipl);

    // One-cycle trap and error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_req <= 1'b0;
            err_ast  <= 1'b0;
        end else begin
            trap_req <= take;
            err_ast  <= eval_armed && ast_bad;
        end
    end

    // Summary and level registers, loaded only when a trap is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_word <= '0;
            int_id   <= '0;
        end else if (take) begin
            sum_word <= sw_bits | ext_bits;
            int_id   <= win_lvl;
        end
    end

    a_r5_trap_above_ipl: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (int_id != '0 && int_id > $past(cur_ipl)));
    a_r7_trap_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(eval_armed));
    a_r6_err_blocks_trap: assert property (@(posedge clk) disable iff (!rst_n)
        err_ast |-> (!trap_req && $stable(sum_word) && $stable(int_id)));
    a_r5_hold_without_trap: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |-> $stable(int_id));
    a_r3_ext_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && $past(ext_hit)) |-> int_id >= LVL_W'(EXT_LO));
endmodule

// File: tb/tb_ipl_evaluator.sv
module tb_ipl_evaluator;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] sw_req, ext_irq;
    logic [4:0]  cur_ipl;
    logic [3:0]  ast_req;
    logic        pal_mode, rfe_strobe, rfe_spec;
    logic        trap_req, err_ast, rfe_fault, eval_armed;
    logic [31:0] sum_word;
    logic [4:0]  int_id;

    int checks = 0;
    int bad    = 0;
    logic [31:0] exp_sum;
    logic [4:0]  exp_id;

    localparam logic [31:0] SW_MASK  = 32'h0007_FFF0;
    localparam logic [31:0] EXT_MASK = 32'h7FF0_0000;

    always #2 clk = ~clk;   // 250 MHz

    ipl_evaluator dut (
        .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .ext_irq(ext_irq),
        .cur_ipl(cur_ipl), .ast_req(ast_req), .pal_mode(pal_mode),
        .rfe_strobe(rfe_strobe), .rfe_spec(rfe_spec), .trap_req(trap_req),
        .sum_word(sum_word), .int_id(int_id), .err_ast(err_ast),
        .rfe_fault(rfe_fault), .eval_armed(eval_armed));

    typedef struct packed {
        logic [31:0] sw;
        logic [31:0] ext;
        logic [4:0]  ipl;
        logic        trap;
        logic [4:0]  id;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VT [NV] = '{
        '{32'h0000_0010, 32'h0, 5'd0,  1'b1, 5'd1},   // R2 lowest sw bit
        '{32'h0004_0020, 32'h0, 5'd0,  1'b1, 5'd15},  // R2 highest sw bit wins
        '{32'h0000_0400, 32'h0, 5'd7,  1'b0, 5'd0},   // R5 equal level
        '{32'h0000_0400, 32'h0, 5'd6,  1'b1, 5'd7},   // R5 one above
        '{32'h0004_0000, 32'h0010_0000, 5'd0, 1'b1, 5'd20}, // R3 override
        '{32'h0, 32'h4020_0000, 5'd29, 1'b1, 5'd30},  // R3 highest ext
        '{32'h0008_000F, 32'h8000_0000, 5'd0, 1'b0, 5'd0}, // R4 outside ranges
        '{32'h0, 32'h0200_0000, 5'd31, 1'b0, 5'd0},   // R5 ipl max
        '{32'h0, 32'h0, 5'd0, 1'b0, 5'd0},            // R5 level zero
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0, 1'b1, 5'd30} // R4 full summary
    };

    task automatic chk(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] s, input logic [31:0] e,
                         input logic [4:0] l, input logic [3:0] a,
                         input logic pm, input logic rf, input logic sp);
        sw_req = s; ext_irq = e; cur_ipl = l; ast_req = a;
        pal_mode = pm; rfe_strobe = rf; rfe_spec = sp;
        @(negedge clk);
    endtask

    initial begin
        #100000;
        bad++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        drive(0, 0, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        // R1 reset state
        chk(trap_req == 0 && err_ast == 0 && rfe_fault == 0, "R1 pulses", {29'b0, trap_req, err_ast, rfe_fault}, 0);
        chk(sum_word == 0 && int_id == 0, "R1 regs", sum_word, 0);
        chk(eval_armed == 1, "R1 armed", eval_armed, 1);
        exp_sum = 0; exp_id = 0;

        for (int k = 0; k < NV; k++) begin
            drive(0, 0, 0, 0, 1, 1, 0);               // R8 rearm
            chk(eval_armed == 1, "R8 rearm", eval_armed, 1);
            drive(VT[k].sw, VT[k].ext, VT[k].ipl, 0, 1, 0, 0);
            if (VT[k].trap) begin
                exp_sum = (VT[k].sw & SW_MASK) | (VT[k].ext & EXT_MASK);
                exp_id  = VT[k].id;
            end
            chk(trap_req == VT[k].trap, "R5 trap", trap_req, VT[k].trap);
            chk(int_id == exp_id, "R2/R3 id", int_id, exp_id);
            chk(sum_word == exp_sum, "R4 summary", sum_word, exp_sum);
            chk(eval_armed == 0, "R7 cleared", eval_armed, 0);
        end

        // R10 trap is a single-cycle pulse; registers hold
        drive(0, 0, 0, 0, 1, 1, 0);
        drive(32'h0000_0100, 0, 0, 0, 1, 0, 0);
        chk(trap_req == 1 && int_id == 5'd5, "R10 pulse on", int_id, 5);
        drive(32'h0000_0100, 0, 0, 0, 1, 0, 0);
        chk(trap_req == 0, "R10 pulse off", trap_req, 0);
        chk(sum_word == 32'h100 && int_id == 5'd5, "R5 hold", sum_word, 32'h100);

        // R7 unarmed: a request produces nothing
        drive(32'h0004_0000, 32'h4000_0000, 0, 0, 1, 0, 0);
        chk(trap_req == 0 && sum_word == 32'h100, "R7 unarmed", sum_word, 32'h100);

        // R9 return outside privileged mode
        drive(0, 0, 0, 0, 0, 1, 0);
        chk(rfe_fault == 1, "R9 fault", rfe_fault, 1);
        chk(eval_armed == 0, "R9 armed unchanged", eval_armed, 0);
        drive(0, 0, 0, 0, 0, 0, 0);
        chk(rfe_fault == 0, "R10 fault pulse off", rfe_fault, 0);

        // R8 speculative return does not rearm
        drive(0, 0, 0, 0, 1, 1, 1);
        chk(eval_armed == 0 && rfe_fault == 0, "R8 speculative", eval_armed, 0);

        // R6 asynchronous trap request raises error, no trap
        drive(0, 0, 0, 0, 1, 1, 0);
        drive(32'h0004_0000, 0, 0, 4'h2, 1, 0, 0);
        chk(err_ast == 1 && trap_req == 0, "R6 error", {trap_req, err_ast}, 2'b01);
        chk(sum_word == 32'h100 && int_id == 5'd5, "R6 regs unchanged", sum_word, 32'h100);
        chk(eval_armed == 0, "R7 cleared by error eval", eval_armed, 0);
        drive(0, 0, 0, 0, 1, 0, 0);
        chk(err_ast == 0, "R10 error pulse off", err_ast, 0);

        // R8 rearm in same cycle as evaluation keeps flag set
        drive(0, 0, 0, 0, 1, 1, 0);
        drive(0, 32'h0080_0000, 0, 0, 1, 1, 0);
        chk(trap_req == 1 && int_id == 5'd23 && eval_armed == 1, "R8 same-cycle rearm", int_id, 23);

        // R1 reset mid-run
        rst_n = 1'b0;
        drive(0, 0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        chk(sum_word == 0 && int_id == 0 && eval_armed == 1 && trap_req == 0, "R1 re-reset", sum_word, 0);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule